// File: doc/BRIEF.md
# Interrupt Request Front-End with Vector Selection

This block connects two active-low external interrupt lines, one fast and one normal, to a processor's exception logic. Each line is either passed straight through or sent through a two-flop synchronizer first. A configuration input makes that choice. Each conditioned request is then qualified by its own enable bit. The qualified requests go to a fixed-priority arbiter in which the fast request wins.

When a request wins, the block registers three things: an exception-taken flag, a two-bit code for the winning source, and the 32-bit vector fetch address. The address is a vector base plus a per-source offset. A second configuration input selects the base, either the bottom of memory or 0xFFFF0000. The registered result holds until the processor pulses an acknowledge. Arbitration then runs again on the following cycle. Disabling the enable of a held request withdraws it.

Top module: `irq_vector_frontend`

## Requirements
- R1: Both request lines are active low and level sensitive. A line that goes low and returns high while its enable is off leaves nothing behind. Enabling it afterwards raises no exception.
- R2: When both requests are active and enabled, the fast one is selected. The source code is 2'b10 for fast, 2'b01 for normal and 2'b00 for none.
- R3: A request whose enable is low never produces an exception.
- R4: With `sync_bypass` high, a line that is low at a rising clock edge is reported by `take` at that same edge. The bypass path adds zero cycles.
- R5: With `sync_bypass` low, the report comes exactly two rising edges later than on the bypass path.
- R6: With `hi_vec` low, `vec_addr` is 0x00000018 for a normal request and 0x0000001C for a fast request.
- R7: With `hi_vec` high, `vec_addr` is 0xFFFF0018 for a normal request and 0xFFFF001C for a fast request.
- R8: `rst_n` is active low and clears `take` asynchronously. No exception is reported while `rst_n` is low.
- R9: `take`, `src` and `vec_addr` hold steady until an `ack` pulse, even if a higher-priority request arrives in the meantime. `ack` clears `take` at the next edge. A request that is still active is taken again one edge later.
- R10: Dropping the enable of the held request withdraws it at the next edge. If the other request is active and enabled at that edge, it becomes the held request instead, with its own code and address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_n | input | 1 | Fast interrupt line, active low |
| norm_n | input | 1 | Normal interrupt line, active low |
| fast_en | input | 1 | Enable for the fast request |
| norm_en | input | 1 | Enable for the normal request |
| sync_bypass | input | 1 | High: lines used directly; low: lines synchronized |
| hi_vec | input | 1 | High: vector base 0xFFFF0000; low: base 0 |
| ack | input | 1 | Acknowledge pulse, clears the held exception |
| take | output | 1 | Exception taken, registered |
| src | output | 2 | Winning source: 10 fast, 01 normal, 00 none |
| vec_addr | output | 32 | Vector fetch address of the held exception |

## Verification
The in-RTL assertions check the following on every cycle:
- `take` and a non-zero source code always agree, and `take` is never high in reset.
- `ack` always clears `take`.
- The result is stable while no `ack` arrives and the held enable stays high.
- The fast request wins a fresh arbitration whenever both are qualified.
- The address base follows `hi_vec`.

Only the bench's scenarios can show the following:
- The exact zero-cycle and two-cycle latencies of the two conditioning paths.
- That a line pulse seen while disabled leaves nothing behind.
- The re-take one edge after an acknowledge.
- The switch to the other source on withdrawal.

A sweep covers every combination of path, base, line levels and enables.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_NORM = 2'b01,
    SRC_FAST = 2'b10
  } irq_src_e;

  localparam logic [31:0] BASE_LOW  = 32'h0000_0000;
  localparam logic [31:0] BASE_HIGH = 32'hFFFF_0000;
  localparam logic [31:0] OFS_NORM  = 32'h0000_0018;
  localparam logic [31:0] OFS_FAST  = 32'h0000_001C;

  // Vector fetch address for a given base selection and winning source
  function automatic logic [31:0] vector_of(input logic high_base, input irq_src_e s);
    logic [31:0] base;
    logic [31:0] ofs;
    base = high_base ? BASE_HIGH : BASE_LOW;
    case (s)
      SRC_FAST: ofs = OFS_FAST;
      SRC_NORM: ofs = OFS_NORM;
      default:  ofs = 32'h0;
    endcase
    return base + ofs;
  endfunction

endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic bypass,
  output logic req
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], line_n};
  end

  // active-high request, taken either from the pin or from the last stage
  assign req = bypass ? ~line_n : ~chain[STAGES-1];
endmodule

// File: rtl/irqfe_arb.sv
module irqfe_arb
  import irqfe_pkg::*;
(
  input  logic     fast_req,
  input  logic     norm_req,
  input  logic     fast_en,
  input  logic     norm_en,
  output logic     fast_act,
  output logic     norm_act,
  output irq_src_e winner
);
  assign fast_act = fast_req & fast_en;
  assign norm_act = norm_req & norm_en;

  always_comb begin
    if (fast_act)      winner = SRC_FAST;
    else if (norm_act) winner = SRC_NORM;
    else               winner = SRC_NONE;
  end
endmodule

// File: rtl/irq_vector_frontend.sv
module irq_vector_frontend
  import irqfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fast_n,
  input  logic        norm_n,
  input  logic        fast_en,
  input  logic        norm_en,
  input  logic        sync_bypass,
  input  logic        hi_vec,
  input  logic        ack,
  output logic        take,
  output logic [1:0]  src,
  output logic [31:0] vec_addr
);
  localparam int NLINES = 2;  // index 1 fast, index 0 normal

  logic [NLINES-1:0] line_n_v;
  logic [NLINES-1:0] req_v;

  assign line_n_v = {fast_n, norm_n};

  for (genvar g = 0; g < NLINES; g++) begin : g_cond
    irqfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_n (line_n_v[g]),
      .bypass (sync_bypass),
      .req    (req_v[g])
    );
  end

  logic     fast_act, norm_act;
  irq_src_e winner;

  irqfe_arb u_arb (
    .fast_req (req_v[1]),
    .norm_req (req_v[0]),
    .fast_en  (fast_en),
    .norm_en  (norm_en),
    .fast_act (fast_act),
    .norm_act (norm_act),
    .winner   (winner)
  );

  // Held exception state
  logic        take_q;
  irq_src_e    src_q;
  logic [31:0] addr_q;

  // Named events for the assertions
  logic held_en;
  logic withdraw;
  logic fresh_pick;

  assign held_en    = (src_q == SRC_FAST) ? fast_en : norm_en;
  assign withdraw   = take_q && !ack && !held_en;
  assign fresh_pick = !take_q && (winner != SRC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      src_q  <= SRC_NONE;
      addr_q <= '0;
    end else if (take_q && ack) begin
      take_q <= 1'b0;
      src_q  <= SRC_NONE;
    end else if (withdraw || fresh_pick) begin
      take_q <= (winner != SRC_NONE);
      src_q  <= winner;
      addr_q <= vector_of(hi_vec, winner);
    end
  end

  assign take     = take_q;
  assign src      = src_q;
  assign vec_addr = addr_q;

  // R2 R3: take and a valid source code always agree
  take_src_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take == (src != 2'b00));

  // R8: nothing reported while reset is applied
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !take);

  // R9: acknowledge clears the held exception at the next edge
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack) |=> !take);

  // R9: held result is steady while no ack arrives and its enable stays on
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ack && held_en) |=> (take && $stable(src) && $stable(vec_addr)));

  // R2: fast wins a fresh arbitration when both are qualified
  fast_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && fast_act && norm_act) |=> (src == 2'b10));

  // R6 R7: address base follows the base selection at the taking edge
  base_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh_pick && hi_vec) |=> (vec_addr[31:16] == 16'hFFFF));

  // R10: withdrawn source is not the one held afterwards
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (withdraw && (src == 2'b10)) |=> (src != 2'b10));
endmodule

// File: tb/test_irq_vector_frontend.sv
module test_irq_vector_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_n = 1'b1, norm_n = 1'b1;
  logic        fast_en = 1'b0, norm_en = 1'b0;
  logic        sync_bypass = 1'b1, hi_vec = 1'b0, ack = 1'b0;
  logic        take;
  logic [1:0]  src;
  logic [31:0] vec_addr;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  irq_vector_frontend i_irq_vector_frontend (
    .clk(clk), .rst_n(rst_n), .fast_n(fast_n), .norm_n(norm_n),
    .fast_en(fast_en), .norm_en(norm_en), .sync_bypass(sync_bypass),
    .hi_vec(hi_vec), .ack(ack), .take(take), .src(src), .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] want_addr(input int h, input int s);
    logic [31:0] a;
    a = (h != 0) ? 32'hFFFF_0000 : 32'h0;
    if (s == 2) a = a + 32'd28;
    else if (s == 1) a = a + 32'd24;
    return a;
  endfunction

  task automatic settle();
    fast_n = 1'b1; norm_n = 1'b1; fast_en = 1'b0; norm_en = 1'b0; ack = 1'b0;
    repeat (4) step();
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R8: reset state
    #1;
    chk("R8 reset take", {31'b0, take}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R8 idle take", {31'b0, take}, 0);
    chk("R8 idle src", {30'b0, src}, 0);

    // Sweep: path x base x line levels x enables
    for (int m = 0; m < 2; m++)
      for (int h = 0; h < 2; h++)
        for (int l = 0; l < 4; l++)
          for (int e = 0; e < 4; e++) begin
            int fa, na, es, et;
            string lat;
            fa = ((l & 2) != 0 && (e & 2) != 0) ? 1 : 0;
            na = ((l & 1) != 0 && (e & 1) != 0) ? 1 : 0;
            es = (fa != 0) ? 2 : (na != 0) ? 1 : 0;
            et = (es != 0) ? 1 : 0;
            lat = (m != 0) ? "R4" : "R5";
            sync_bypass = (m != 0); hi_vec = (h != 0);
            fast_n = ((l & 2) == 0); norm_n = ((l & 1) == 0);
            fast_en = ((e & 2) != 0); norm_en = ((e & 1) != 0);
            step();
            chk({lat, " edge1 take"}, {31'b0, take}, (m != 0) ? et : 0);
            step();
            chk({lat, " edge2 take"}, {31'b0, take}, (m != 0) ? et : 0);
            step();
            chk("R3 take", {31'b0, take}, et);
            chk("R2 src", {30'b0, src}, es);
            if (et != 0)
              chk((h != 0) ? "R7 addr" : "R6 addr", vec_addr, want_addr(h, es));
            if (et != 0) begin
              ack = 1'b1;
              step();
              ack = 1'b0;
              chk("R9 ack clears", {31'b0, take}, 0);
              step();
              chk("R9 retake", {31'b0, take}, 1);
              chk("R9 retake src", {30'b0, src}, es);
            end
            settle();
            chk("R10 cleared", {31'b0, take}, 0);
          end

    // R1: pulse while disabled leaves nothing
    sync_bypass = 1'b1; hi_vec = 1'b0;
    fast_n = 1'b0; step(); fast_n = 1'b1; step();
    fast_en = 1'b1; step(); step();
    chk("R1 no latch", {31'b0, take}, 0);
    settle();

    // R9: hold steady when fast arrives after normal taken
    norm_en = 1'b1; fast_en = 1'b1; norm_n = 1'b0; step();
    chk("R9 normal held", {30'b0, src}, 1);
    fast_n = 1'b0; step(); step();
    chk("R9 holds src", {30'b0, src}, 1);
    chk("R9 holds addr", vec_addr, 32'h18);
    settle();

    // R10: withdraw fast, switch to normal, then withdraw normal
    hi_vec = 1'b1; fast_en = 1'b1; norm_en = 1'b1;
    fast_n = 1'b0; norm_n = 1'b0; step();
    chk("R10 fast first", {30'b0, src}, 2);
    fast_en = 1'b0; step();
    chk("R10 switch src", {30'b0, src}, 1);
    chk("R10 switch take", {31'b0, take}, 1);
    chk("R10 switch addr", vec_addr, 32'hFFFF_0018);
    norm_en = 1'b0; step();
    chk("R10 withdrawn", {31'b0, take}, 0);
    settle();

    // R8: asynchronous reset while taken, and quiet during reset
    norm_en = 1'b1; norm_n = 1'b0; step();
    chk("R8 pre take", {31'b0, take}, 1);
    #2 rst_n = 1'b0;
    #1 chk("R8 async clear", {31'b0, take}, 0);
    step(); step();
    chk("R8 quiet", {31'b0, take}, 0);
    rst_n = 1'b1;
    settle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule